// File: doc/BRIEF.md
# Sleep-State Power Sequencer

This block drives the sleep-level control outputs of a system as it goes into suspend and comes back out. Entry starts when a suspend request and the processor-sleep indication are both high while the system is awake. The block then asserts a suspend-status flag, a bus reset, and the active-low sleep signals for S3, S4 and S5 in a fixed cascade. It stops at the depth that the request selects. Every delay in the cascade is counted in pulses of a slow tick-enable input of about 32 µs. Each delay is a parameter, and its default is the shortest delay the timing windows allow.

A wake event releases the signals in the reverse order. The release starts at the deepest level that is asserted. A wake that arrives while entry is still running is held and acted on once entry has finished. A thermal-trip input bypasses the tick timing. On the fast bus clock it forces all three sleep signals active, and it holds them there until the suspend-well reset clears the block.

Top module: `sleep_seq`

## Requirements
- R1: After reset, and while no suspend has begun, `susp_stat_o` and `bus_rst_o` are 0 and all three sleep outputs are 1. Entry begins only on a clock edge at which `susp_req_i` and `cpu_slp_i` are both 1 in the awake state. `tgt_i` is sampled at that edge, with the encoding 1 = S3, 2 = S4, 3 = S5 and 0 treated as S3.
- R2: `susp_stat_o` rises on the edge that samples the DLY_STAT-th tick (default 2, window 2 to 4) after the start edge. A tick that is high on the start edge itself is not counted.
- R3: `bus_rst_o` rises on the edge of the DLY_BRST-th tick (default 9, window 9 to 21) after `susp_stat_o` rose.
- R4: S3, S4 and S5 assert in that order. Each asserts DLY_STEP ticks (default 1, window 1 to 2) after the previous step, with S3 counted from the rise of `bus_rst_o`. S4 is never active without S3, and S5 is never active without S4.
- R5: For target S3 the cascade ends after S3, with S4 and S5 left high. For target S4 it ends after S4, with S5 left high.
- R6: A wake in the fully entered state releases the deepest active sleep output DLY_STEP ticks after the wake edge. The remaining sleep outputs follow, deepest first, and then `bus_rst_o` and `susp_stat_o`, each DLY_STEP ticks after the previous release. The block then returns to the awake state.
- R7: A wake that arrives during entry is held. The first release comes DLY_STEP ticks after the step that completes entry.
- R8: A thermal trip sampled high drives all three sleep outputs to 0 by the next clock edge. They stay at 0 until reset. While the trip is latched, the cascade is frozen and wake events are ignored.
- R9: A wake in the awake state, or during a release, has no effect. Apart from a thermal trip, outputs change only on edges that sample a tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bus clock (about 33 MHz) |
| rst_ni | input | 1 | Suspend-well reset, active low, asynchronous |
| tick_i | input | 1 | One-cycle slow tick enable (about 32 µs) |
| susp_req_i | input | 1 | Suspend request |
| tgt_i | input | 2 | Target sleep level: 1 = S3, 2 = S4, 3 = S5, 0 = S3 |
| cpu_slp_i | input | 1 | Processor has entered sleep |
| wake_i | input | 1 | Wake event |
| therm_trip_i | input | 1 | Thermal trip |
| susp_stat_o | output | 1 | Suspend status, active high |
| bus_rst_o | output | 1 | Bus reset, active high |
| slp_s3_n_o | output | 1 | S3 sleep level, active low |
| slp_s4_n_o | output | 1 | S4 sleep level, active low |
| slp_s5_n_o | output | 1 | S5 sleep level, active low |

## Verification
The cascade is run with each of the three targets. Comparing the three runs shows that the stopping point and the first released level follow the depth that was reached rather than a fixed order. A wake is injected during entry, while the bus-reset delay is running, to tell a held wake apart from one that was dropped or acted on early. Wakes in the awake state, and a request given without the processor-sleep indication, show that the start condition needs both inputs. A thermal trip in the middle of entry, followed by a wake, separates the fast forcing path and its latch from the tick-paced cascade.

// File: rtl/sleep_seq_pkg.sv
package sleep_seq_pkg;
  typedef enum logic [3:0] {
    PH_AWAKE, PH_STAT, PH_BRST, PH_S3, PH_S4, PH_S5, PH_SLEEP,
    PH_R5, PH_R4, PH_R3, PH_RBRST, PH_RSTAT
  } phase_e;

  typedef enum logic [1:0] {
    TGT_S3A = 2'd0, TGT_S3 = 2'd1, TGT_S4 = 2'd2, TGT_S5 = 2'd3
  } tgt_e;

  typedef struct packed {
    logic stat;
    logic brst;
    logic s3;
    logic s4;
    logic s5;
  } lvl_t;
endpackage

// File: rtl/sleep_seq_delay.sv
module sleep_seq_delay #(
  parameter int unsigned CW = 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clr_i,
  input  logic          tick_i,
  input  logic [CW-1:0] lim_i,
  output logic          done_o
);
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (clr_i)  cnt_q <= '0;
    else if (tick_i) cnt_q <= cnt_q + CW'(1);
  end

  // done on the lim-th tick counted since the last clear
  assign done_o = tick_i && (cnt_q == lim_i - CW'(1));
endmodule

// File: rtl/sleep_seq_trip.sv
module sleep_seq_trip (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic trip_i,
  output logic trip_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     trip_o <= 1'b0;
    else if (trip_i) trip_o <= 1'b1;
  end
endmodule

// File: rtl/sleep_seq_fsm.sv
module sleep_seq_fsm
  import sleep_seq_pkg::*;
#(
  parameter int unsigned CW       = 5,
  parameter int unsigned DLY_STAT = 2,
  parameter int unsigned DLY_BRST = 9,
  parameter int unsigned DLY_STEP = 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic [1:0]    tgt_i,
  input  logic          wake_i,
  input  logic          frz_i,
  input  logic          done_i,
  output logic          clr_o,
  output logic [CW-1:0] lim_o,
  output lvl_t          lvl_o
);
  phase_e ph_q, ph_d;
  lvl_t   lvl_q, lvl_d;
  tgt_e   tgt_q, tgt_d;
  logic   pend_q, pend_d;

  always_comb begin
    case (ph_q)
      PH_STAT: lim_o = CW'(DLY_STAT);
      PH_BRST: lim_o = CW'(DLY_BRST);
      default: lim_o = CW'(DLY_STEP);
    endcase
  end

  always_comb begin
    ph_d   = ph_q;
    lvl_d  = lvl_q;
    tgt_d  = tgt_q;
    pend_d = pend_q;
    if (!frz_i) begin
      case (ph_q)
        PH_AWAKE: if (start_i) begin tgt_d = tgt_e'(tgt_i); ph_d = PH_STAT; end
        PH_STAT:  if (done_i) begin lvl_d.stat = 1'b1; ph_d = PH_BRST; end
        PH_BRST:  if (done_i) begin lvl_d.brst = 1'b1; ph_d = PH_S3; end
        PH_S3: if (done_i) begin
          lvl_d.s3 = 1'b1;
          ph_d = (tgt_q == TGT_S3 || tgt_q == TGT_S3A) ? PH_SLEEP : PH_S4;
        end
        PH_S4: if (done_i) begin
          lvl_d.s4 = 1'b1;
          ph_d = (tgt_q == TGT_S4) ? PH_SLEEP : PH_S5;
        end
        PH_S5: if (done_i) begin lvl_d.s5 = 1'b1; ph_d = PH_SLEEP; end
        PH_SLEEP: if (wake_i || pend_q) begin
          pend_d = 1'b0;
          ph_d = lvl_q.s5 ? PH_R5 : (lvl_q.s4 ? PH_R4 : PH_R3);
        end
        PH_R5:    if (done_i) begin lvl_d.s5 = 1'b0; ph_d = PH_R4; end
        PH_R4:    if (done_i) begin lvl_d.s4 = 1'b0; ph_d = PH_R3; end
        PH_R3:    if (done_i) begin lvl_d.s3 = 1'b0; ph_d = PH_RBRST; end
        PH_RBRST: if (done_i) begin lvl_d.brst = 1'b0; ph_d = PH_RSTAT; end
        PH_RSTAT: if (done_i) begin lvl_d.stat = 1'b0; ph_d = PH_AWAKE; end
        default:  ph_d = PH_AWAKE;
      endcase
      // hold a wake that lands mid-entry
      if (wake_i && (ph_q inside {PH_STAT, PH_BRST, PH_S3, PH_S4, PH_S5}))
        pend_d = 1'b1;
    end
  end

  assign clr_o = (ph_d != ph_q);
  assign lvl_o = lvl_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ph_q   <= PH_AWAKE;
      lvl_q  <= '0;
      tgt_q  <= TGT_S3;
      pend_q <= 1'b0;
    end else begin
      ph_q   <= ph_d;
      lvl_q  <= lvl_d;
      tgt_q  <= tgt_d;
      pend_q <= pend_d;
    end
  end
endmodule

// File: rtl/sleep_seq.sv
module sleep_seq
  import sleep_seq_pkg::*;
#(
  parameter int unsigned DLY_STAT = 2,
  parameter int unsigned DLY_BRST = 9,
  parameter int unsigned DLY_STEP = 1
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       tick_i,
  input  logic       susp_req_i,
  input  logic [1:0] tgt_i,
  input  logic       cpu_slp_i,
  input  logic       wake_i,
  input  logic       therm_trip_i,
  output logic       susp_stat_o,
  output logic       bus_rst_o,
  output logic       slp_s3_n_o,
  output logic       slp_s4_n_o,
  output logic       slp_s5_n_o
);
  localparam int unsigned DMAX_A = (DLY_STAT > DLY_STEP) ? DLY_STAT : DLY_STEP;
  localparam int unsigned DMAX   = (DLY_BRST > DMAX_A) ? DLY_BRST : DMAX_A;
  localparam int unsigned CW     = $clog2(DMAX + 1);

  logic          trip;
  logic          clr;
  logic          done;
  logic [CW-1:0] lim;
  lvl_t          lvl;

  sleep_seq_trip u_trip (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .trip_i (therm_trip_i),
    .trip_o (trip)
  );

  sleep_seq_delay #(.CW(CW)) u_dly (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (clr),
    .tick_i (tick_i),
    .lim_i  (lim),
    .done_o (done)
  );

  sleep_seq_fsm #(
    .CW(CW), .DLY_STAT(DLY_STAT), .DLY_BRST(DLY_BRST), .DLY_STEP(DLY_STEP)
  ) u_fsm (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (susp_req_i & cpu_slp_i),
    .tgt_i   (tgt_i),
    .wake_i  (wake_i),
    .frz_i   (trip),
    .done_i  (done),
    .clr_o   (clr),
    .lim_o   (lim),
    .lvl_o   (lvl)
  );

  assign susp_stat_o = lvl.stat;
  assign bus_rst_o   = lvl.brst;
  assign slp_s3_n_o  = ~(lvl.s3 | trip);
  assign slp_s4_n_o  = ~(lvl.s4 | trip);
  assign slp_s5_n_o  = ~(lvl.s5 | trip);
endmodule

// File: rtl/sleep_seq_chk.sv
module sleep_seq_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic tick_i,
  input logic therm_trip_i,
  input logic trip_i,
  input logic susp_stat_o,
  input logic bus_rst_o,
  input logic slp_s3_n_o,
  input logic slp_s4_n_o,
  input logic slp_s5_n_o
);
  a_r4_s4_needs_s3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !slp_s4_n_o |-> !slp_s3_n_o);

  a_r4_s5_needs_s4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !slp_s5_n_o |-> !slp_s4_n_o);

  a_r6_brst_within_stat: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_rst_o |-> susp_stat_o);

  a_r8_trip_fast: assert property (@(posedge clk_i) disable iff (!rst_ni)
    therm_trip_i |=> (!slp_s3_n_o && !slp_s4_n_o && !slp_s5_n_o));

  a_r9_tick_paced: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!trip_i && !$past(tick_i)) |->
      $stable({susp_stat_o, bus_rst_o, slp_s3_n_o, slp_s4_n_o, slp_s5_n_o}));
endmodule

bind sleep_seq sleep_seq_chk u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .tick_i       (tick_i),
  .therm_trip_i (therm_trip_i),
  .trip_i       (trip),
  .susp_stat_o  (susp_stat_o),
  .bus_rst_o    (bus_rst_o),
  .slp_s3_n_o   (slp_s3_n_o),
  .slp_s4_n_o   (slp_s4_n_o),
  .slp_s5_n_o   (slp_s5_n_o)
);

// File: tb/sleep_seq_bench.sv
module sleep_seq_bench;
  localparam int CLK_P    = 10;
  localparam int TICK_DIV = 4;
  localparam int D_STAT   = 2;
  localparam int D_BRST   = 9;
  localparam int D_STEP   = 1;

  logic clk = 1'b0, rst_n = 1'b0, tick = 1'b0;
  logic susp_req = 1'b0, cpu_slp = 1'b0, wake = 1'b0, trip = 1'b0;
  logic [1:0] tgt = 2'd0;
  logic stat_o, brst_o, s3_n, s4_n, s5_n;

  int n_chk = 0, n_bad = 0, cyc = 0, ticks = 0, div = 0;
  string cur_req = "R1";

  always #(CLK_P/2) clk = ~clk;

  sleep_seq u_sleep_seq (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .susp_req_i(susp_req),
    .tgt_i(tgt), .cpu_slp_i(cpu_slp), .wake_i(wake), .therm_trip_i(trip),
    .susp_stat_o(stat_o), .bus_rst_o(brst_o),
    .slp_s3_n_o(s3_n), .slp_s4_n_o(s4_n), .slp_s5_n_o(s5_n)
  );

  always @(negedge clk) begin
    tick <= (div == TICK_DIV - 1);
    div  <= (div + 1) % TICK_DIV;
  end
  always @(posedge clk) if (tick) ticks <= ticks + 1;

  // reference model: an action queue counting ticks down
  bit m_on [5];
  int q_act[$], q_cnt[$];
  bit m_sleep, m_pend, m_trip, m_rel;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < 5; i++) m_on[i] = 1'b0;
      q_act.delete(); q_cnt.delete();
      m_sleep = 0; m_pend = 0; m_trip = 0; m_rel = 0;
    end else begin
      if (!m_trip) begin
        if (q_act.size() > 0) begin
          if (!m_rel && wake) m_pend = 1;
          if (tick) begin
            q_cnt[0] = q_cnt[0] - 1;
            if (q_cnt[0] == 0) begin
              if (q_act[0] < 5) m_on[q_act[0]] = 1'b1;
              else              m_on[q_act[0] - 5] = 1'b0;
              void'(q_act.pop_front()); void'(q_cnt.pop_front());
              if (q_act.size() == 0) begin
                if (m_rel) m_rel = 0; else m_sleep = 1;
              end
            end
          end
        end else if (m_sleep) begin
          if (wake || m_pend) begin
            m_pend = 0; m_sleep = 0; m_rel = 1;
            for (int i = 4; i >= 0; i--)
              if (m_on[i]) begin q_act.push_back(i + 5); q_cnt.push_back(D_STEP); end
          end
        end else if (susp_req && cpu_slp) begin
          q_act.push_back(0); q_cnt.push_back(D_STAT);
          q_act.push_back(1); q_cnt.push_back(D_BRST);
          q_act.push_back(2); q_cnt.push_back(D_STEP);
          if (tgt >= 2) begin q_act.push_back(3); q_cnt.push_back(D_STEP); end
          if (tgt == 3) begin q_act.push_back(4); q_cnt.push_back(D_STEP); end
        end
      end
      if (trip) m_trip = 1;
    end
  end

  task automatic chk(input string req, input int act, input int exp, input string what);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s act=%0d exp=%0d", req, what, act, exp);
    end
  endtask

  always @(negedge clk) if (rst_n) begin
    chk(cur_req, {stat_o, brst_o, s3_n, s4_n, s5_n},
        {m_on[0], m_on[1], !(m_on[2] || m_trip), !(m_on[3] || m_trip), !(m_on[4] || m_trip)},
        "model compare");
  end

  function automatic logic outv(input int k);
    case (k)
      0: return stat_o;
      1: return brst_o;
      2: return s3_n;
      3: return s4_n;
      default: return s5_n;
    endcase
  endfunction

  task automatic wait_sig(input int k, input logic v, output int t);
    int n = 0;
    while (outv(k) !== v && n < 400) begin @(negedge clk); n++; end
    if (n >= 400) chk(cur_req, outv(k), v, "timeout waiting output");
    t = ticks;
  endtask

  task automatic start(input logic [1:0] tg, output int t0);
    @(negedge clk); susp_req = 1; cpu_slp = 1; tgt = tg;
    @(negedge clk); t0 = ticks; susp_req = 0;
  endtask

  task automatic pulse_wake(output int tw);
    @(negedge clk); wake = 1;
    @(negedge clk); wake = 0; tw = ticks;
  endtask

  task automatic idle_chk(input string req);
    chk(req, {stat_o, brst_o, s3_n, s4_n, s5_n}, 5'b00111, "idle outputs");
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog act=%0d exp=done", cyc);
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    int t0, t1, t2, t3, t4, t5, tw;
    repeat (3) @(negedge clk);
    idle_chk("R1");
    rst_n = 1;
    repeat (3) @(negedge clk);
    idle_chk("R1");

    // full cascade to S5 and wake
    cur_req = "R4";
    start(2'd3, t0);
    wait_sig(0, 1, t1); chk("R2", t1 - t0, D_STAT, "ticks to status");
    wait_sig(1, 1, t2); chk("R3", t2 - t1, D_BRST, "ticks to bus reset");
    wait_sig(2, 0, t3); chk("R4", t3 - t2, D_STEP, "ticks to S3");
    wait_sig(3, 0, t4); chk("R4", t4 - t3, D_STEP, "ticks to S4");
    wait_sig(4, 0, t5); chk("R4", t5 - t4, D_STEP, "ticks to S5");
    repeat (10) @(negedge clk);
    cur_req = "R6";
    pulse_wake(tw);
    wait_sig(4, 1, t1); chk("R6", t1 - tw, D_STEP, "S5 release");
    wait_sig(3, 1, t2); chk("R6", t2 - t1, D_STEP, "S4 release");
    wait_sig(2, 1, t3); chk("R6", t3 - t2, D_STEP, "S3 release");
    wait_sig(1, 0, t4); chk("R6", t4 - t3, D_STEP, "bus reset release");
    wait_sig(0, 0, t5); chk("R6", t5 - t4, D_STEP, "status release");
    repeat (4) @(negedge clk);
    idle_chk("R6");

    // target S3
    cur_req = "R5";
    start(2'd1, t0);
    wait_sig(2, 0, t3);
    repeat (40) @(negedge clk);
    chk("R5", {s4_n, s5_n}, 2'b11, "S3 target leaves S4 S5 off");
    pulse_wake(tw);
    wait_sig(2, 1, t1); chk("R6", t1 - tw, D_STEP, "S3 wake first release");
    wait_sig(0, 0, t5);

    // target S4 with wake during entry
    cur_req = "R7";
    start(2'd2, t0);
    wait_sig(0, 1, t1);
    pulse_wake(tw);
    wait_sig(3, 0, t4);
    chk("R5", s5_n, 1, "S4 target leaves S5 off");
    wait_sig(3, 1, t5); chk("R7", t5 - t4, D_STEP, "held wake release");
    chk("R7", s3_n, 0, "S3 still held after S4 release");
    wait_sig(0, 0, t5);
    repeat (4) @(negedge clk);
    idle_chk("R7");

    // ignored stimulus
    cur_req = "R9";
    pulse_wake(tw);
    repeat (20) @(negedge clk);
    idle_chk("R9");
    @(negedge clk); cpu_slp = 0; susp_req = 1; tgt = 2'd3;
    repeat (20) @(negedge clk);
    susp_req = 0;
    idle_chk("R1");

    // thermal trip mid entry
    cur_req = "R8";
    start(2'd3, t0);
    wait_sig(1, 1, t2);
    @(negedge clk); trip = 1;
    @(negedge clk); trip = 0;
    chk("R8", {s3_n, s4_n, s5_n}, 3'b000, "trip forces sleep");
    pulse_wake(tw);
    repeat (80) @(negedge clk);
    chk("R8", {stat_o, brst_o, s3_n, s4_n, s5_n}, 5'b11000, "trip latched, frozen");
    @(negedge clk); rst_n = 0;
    @(negedge clk);
    idle_chk("R1");
    rst_n = 1;
    repeat (4) @(negedge clk);
    idle_chk("R8");

    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule